// File: doc/BRIEF.md
# DMA Channel Run-State Sequencer

This block is the control sequencer for a single DMA channel. It keeps the channel in one of three run states: off, running or held. It reports that state as a 2-bit status code, and any latched fault overrides the code. Software drives it through control writes that carry an enable bit, a continue bit and a continue-from-start bit. The datapath drives it through completion and fault strobes from the descriptor and data units.

While the channel runs, the sequencer repeats a fixed three-step loop. First it asks for the descriptor pointers to be set up: a reload from the start registers or an advance to the next descriptor. Next it issues a fetch-and-transfer request. Then it waits until the descriptor finishes or its load fails. When a descriptor finishes, the descriptor's command field and the addressing mode decide the next step: stop, hold, or advance and loop again. The sequencer moves no data and reads no descriptor memory itself.

Top module: `chan_seq`

## Requirements
- R1: After reset, `run_status` is 0 (off), `en_bit` and `cont_bit` are 0, and no request or event output is high.
- R2: A control write with enable=1 while off clears any fault. It then drives `load_ptr_req` high for one cycle, with `run_status`=1, starting in the cycle after the write. `fetch_req` is high in the cycle after that.
- R3: A `load_err` pulse while waiting on a descriptor makes `run_status` read 3 from the next cycle. The channel is then off underneath, and the code stays 3 until a control write with enable=1, which restarts the channel as in R2.
- R4: `desc_done` while waiting on a descriptor gives a one-cycle `dma_done_evt` in the next cycle. `src_done_evt` pulses in that same cycle only if `desc_intr` was 1.
- R5: With `list_mode`=0 (register mode), every completed descriptor clears `en_bit` and returns `run_status` to 0, whatever the command.
- R6: With `list_mode`=1, command value 2 (stop) clears `en_bit` and returns `run_status` to 0.
- R7: With `list_mode`=1, command value 1 (halt) sets `run_status` to 2 (held) and pulses `pause_evt` once.
- R8: With `list_mode`=1, command values 0 and 3 drive `adv_ptr_req` for one cycle and then `fetch_req`, while `run_status` stays 1.
- R9: While held, a write with enable=1 and continue=1 restarts the channel. It asserts `load_ptr_req` if continue-from-start is 1, or `adv_ptr_req` if it is 0. `cont_bit` reads 0 afterwards, and `run_status` returns to 1.
- R10: While held, a write with enable=0 and continue=1 moves the channel to off (`run_status`=0) and issues no request.
- R11: A control write that matches no transition leaves `run_status` unchanged and issues no request. Examples are enable=1 with continue=0 while held, or any write while running.
- R12: At most one of `load_ptr_req`, `adv_ptr_req` and `fetch_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Written enable bit |
| ctl_cont | input | 1 | Written continue bit |
| ctl_from_start | input | 1 | Written continue-from-start bit |
| list_mode | input | 1 | 1 = descriptors chained in memory, 0 = register mode |
| desc_done | input | 1 | Descriptor finished |
| desc_cmd | input | 2 | Command field of finished descriptor |
| desc_intr | input | 1 | Interrupt bit of finished descriptor |
| load_err | input | 1 | Descriptor load failed |
| en_bit | output | 1 | Stored enable bit |
| cont_bit | output | 1 | Stored continue bit |
| run_status | output | 2 | 0 off, 1 running, 2 held, 3 fault |
| load_ptr_req | output | 1 | Reload pointers from start registers |
| adv_ptr_req | output | 1 | Advance source pointer |
| fetch_req | output | 1 | Fetch and transfer current descriptor |
| dma_done_evt | output | 1 | Descriptor-complete event pulse |
| src_done_evt | output | 1 | Source-done event pulse |
| pause_evt | output | 1 | Held event pulse |

## Verification
A wrong phase in the sequencer appears at the ports within one or two cycles. It shows as a request issued out of order, since every pointer request must be followed by a fetch on the next cycle. It also shows as a status code that disagrees with the last completion or control write. A lost or stuck fault latch appears on the first cycle after the failed load, as a status other than 3, or as a 3 that survives an enable write. Command decoding errors appear as a hold where a stop was expected, or the reverse, on the cycle after completion.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  localparam int CMD_W = 2;
  localparam int STAT_W = 2;
  localparam logic [CMD_W-1:0] CMD_HALT = 2'd1;
  localparam logic [CMD_W-1:0] CMD_STOP = 2'd2;
  localparam logic [STAT_W-1:0] ST_OFF = 2'd0;
  localparam logic [STAT_W-1:0] ST_RUN = 2'd1;
  localparam logic [STAT_W-1:0] ST_HOLD = 2'd2;
  localparam logic [STAT_W-1:0] ST_FAULT = 2'd3;

  typedef enum logic [2:0] {PH_OFF, PH_ARM, PH_FETCH, PH_WAIT, PH_HOLD} phase_t;
  typedef enum logic [1:0] {V_STOP, V_HOLD, V_NEXT} verdict_t;

  // Decision after a finished descriptor.
  function automatic verdict_t judge(input logic chained, input logic [CMD_W-1:0] cmd);
    if (!chained || cmd == CMD_STOP) return V_STOP;
    if (cmd == CMD_HALT) return V_HOLD;
    return V_NEXT;
  endfunction

  // Status code seen by software; a fault overrides the phase.
  function automatic logic [STAT_W-1:0] status_of(input phase_t ph, input logic fault);
    if (fault) return ST_FAULT;
    case (ph)
      PH_OFF:  return ST_OFF;
      PH_HOLD: return ST_HOLD;
      default: return ST_RUN;
    endcase
  endfunction
endpackage

// File: rtl/chan_seq_ctl.sv
module chan_seq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_en,
  input  logic w_cont,
  input  logic resume_now,
  input  logic stop_clr_en,
  output logic en_q,
  output logic cont_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (wr) begin
      en_q <= w_en;
      cont_q <= resume_now ? 1'b0 : w_cont;
    end else if (stop_clr_en) begin
      en_q <= 1'b0;
    end
  end

  // R9
  cont_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_now |=> !cont_q);
endmodule

// File: rtl/chan_seq_fsm.sv
module chan_seq_fsm
  import chan_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_en,
  input  logic w_cont,
  input  logic w_from_start,
  input  logic chained,
  input  logic desc_done,
  input  logic [CMD_W-1:0] desc_cmd,
  input  logic load_err,
  output logic [STAT_W-1:0] status,
  output logic load_req,
  output logic adv_req,
  output logic fetch_req,
  output logic stop_clr_en,
  output logic resume_now,
  output logic done_take,
  output logic pause_take
);
  phase_t ph;
  logic arm_load;
  logic fault;
  verdict_t verdict;

  assign verdict = judge(chained, desc_cmd);
  assign done_take = (ph == PH_WAIT) && desc_done && !load_err;
  assign stop_clr_en = done_take && (verdict == V_STOP);
  assign pause_take = done_take && (verdict == V_HOLD);
  assign resume_now = (ph == PH_HOLD) && wr && w_en && w_cont;
  assign load_req = (ph == PH_ARM) && arm_load;
  assign adv_req = (ph == PH_ARM) && !arm_load;
  assign fetch_req = (ph == PH_FETCH);
  assign status = status_of(ph, fault);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_OFF;
      arm_load <= 1'b0;
      fault <= 1'b0;
    end else begin
      case (ph)
        PH_OFF: if (wr && w_en) begin
          fault <= 1'b0;
          arm_load <= 1'b1;
          ph <= PH_ARM;
        end
        PH_HOLD: if (wr && w_cont) begin
          if (w_en) begin
            arm_load <= w_from_start;
            ph <= PH_ARM;
          end else begin
            ph <= PH_OFF;
          end
        end
        PH_ARM:   ph <= PH_FETCH;
        PH_FETCH: ph <= PH_WAIT;
        PH_WAIT: if (load_err) begin
          fault <= 1'b1;
          ph <= PH_OFF;
        end else if (desc_done) begin
          case (verdict)
            V_STOP: ph <= PH_OFF;
            V_HOLD: ph <= PH_HOLD;
            default: begin
              arm_load <= 1'b0;
              ph <= PH_ARM;
            end
          endcase
        end
        default: ph <= PH_OFF;
      endcase
    end
  end

  // R12
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_req, adv_req, fetch_req}));
  // R2
  load_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> fetch_req);
  // R8
  adv_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_req |=> fetch_req);
  // R3
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && load_err) |=> status == ST_FAULT);
  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_take |=> status == ST_HOLD);
  // R10
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HOLD && wr && !w_en && w_cont) |=> status == ST_OFF);
endmodule

// File: rtl/chan_seq_evt.sv
module chan_seq_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic done_take,
  input  logic intr,
  input  logic pause_take,
  output logic dma_done_q,
  output logic src_done_q,
  output logic pause_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_done_q <= 1'b0;
      src_done_q <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      dma_done_q <= done_take;
      src_done_q <= done_take && intr;
      pause_q <= pause_take;
    end
  end

  // R4
  src_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_done_q |-> dma_done_q);
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_en,
  input  logic ctl_cont,
  input  logic ctl_from_start,
  input  logic list_mode,
  input  logic desc_done,
  input  logic [CMD_W-1:0] desc_cmd,
  input  logic desc_intr,
  input  logic load_err,
  output logic en_bit,
  output logic cont_bit,
  output logic [STAT_W-1:0] run_status,
  output logic load_ptr_req,
  output logic adv_ptr_req,
  output logic fetch_req,
  output logic dma_done_evt,
  output logic src_done_evt,
  output logic pause_evt
);
  logic stop_clr_en, resume_now, done_take, pause_take;

  chan_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .w_en(ctl_en), .w_cont(ctl_cont),
    .w_from_start(ctl_from_start), .chained(list_mode), .desc_done(desc_done),
    .desc_cmd(desc_cmd), .load_err(load_err), .status(run_status),
    .load_req(load_ptr_req), .adv_req(adv_ptr_req), .fetch_req(fetch_req),
    .stop_clr_en(stop_clr_en), .resume_now(resume_now),
    .done_take(done_take), .pause_take(pause_take)
  );

  chan_seq_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .w_en(ctl_en), .w_cont(ctl_cont),
    .resume_now(resume_now), .stop_clr_en(stop_clr_en),
    .en_q(en_bit), .cont_q(cont_bit)
  );

  chan_seq_evt evt_i (
    .clk(clk), .rst_n(rst_n), .done_take(done_take), .intr(desc_intr),
    .pause_take(pause_take), .dma_done_q(dma_done_evt),
    .src_done_q(src_done_evt), .pause_q(pause_evt)
  );

  // R6
  stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clr_en && !ctl_wr) |=> (!en_bit && run_status == ST_OFF));
endmodule

// File: tb/chan_seq_tb_top.sv
module chan_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_cont = 0, ctl_from_start = 0;
  logic list_mode = 1'b1;
  logic desc_done = 0, desc_intr = 0, load_err = 0;
  logic [1:0] desc_cmd = 2'd0;
  logic en_bit, cont_bit, load_ptr_req, adv_ptr_req, fetch_req;
  logic dma_done_evt, src_done_evt, pause_evt;
  logic [1:0] run_status;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_cont(ctl_cont), .ctl_from_start(ctl_from_start), .list_mode(list_mode),
    .desc_done(desc_done), .desc_cmd(desc_cmd), .desc_intr(desc_intr),
    .load_err(load_err), .en_bit(en_bit), .cont_bit(cont_bit),
    .run_status(run_status), .load_ptr_req(load_ptr_req),
    .adv_ptr_req(adv_ptr_req), .fetch_req(fetch_req),
    .dma_done_evt(dma_done_evt), .src_done_evt(src_done_evt),
    .pause_evt(pause_evt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return {29'd0, load_ptr_req, adv_ptr_req, fetch_req};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic en, input logic cont, input logic fs);
    ctl_wr = 1; ctl_en = en; ctl_cont = cont; ctl_from_start = fs;
    step();
    ctl_wr = 0; ctl_en = 0; ctl_cont = 0; ctl_from_start = 0;
  endtask

  task automatic finish_desc(input logic [1:0] cmd, input logic intr);
    desc_done = 1; desc_cmd = cmd; desc_intr = intr;
    step();
    desc_done = 0; desc_cmd = 0; desc_intr = 0;
  endtask

  // Enable from off and walk to the waiting phase.
  task automatic start_run(input string tag);
    write_ctl(1, 0, 0);
    check({tag, " status running"}, run_status, 1);
    check({tag, " load request only"}, reqs(), 4);
    step();
    check({tag, " fetch follows"}, reqs(), 1);
    step();
  endtask

  task automatic t_reset();
    check("R1 status", run_status, 0);
    check("R1 en_bit", en_bit, 0);
    check("R1 cont_bit", cont_bit, 0);
    check("R1 no requests", reqs(), 0);
    check("R1 no events", {dma_done_evt, src_done_evt, pause_evt}, 0);
  endtask

  task automatic t_chain_advance();
    list_mode = 1;
    start_run("R2");
    check("R2 en_bit set", en_bit, 1);
    finish_desc(2'd0, 1'b1);
    check("R4 dma_done pulse", dma_done_evt, 1);
    check("R4 src_done with intr", src_done_evt, 1);
    check("R8 advance request", reqs(), 2);
    check("R8 still running", run_status, 1);
    step();
    check("R4 dma_done one cycle", dma_done_evt, 0);
    check("R8 fetch after advance", reqs(), 1);
    step();
    finish_desc(2'd3, 1'b0);
    check("R8 cmd3 advances", reqs(), 2);
    check("R4 no src_done without intr", src_done_evt, 0);
    step(); step();
  endtask

  task automatic t_halt_resume();
    finish_desc(2'd1, 1'b0);
    check("R7 held status", run_status, 2);
    check("R7 pause event", pause_evt, 1);
    check("R4 dma_done on halt", dma_done_evt, 1);
    step();
    check("R7 pause event one cycle", pause_evt, 0);
    write_ctl(1, 0, 0);
    check("R11 held stays held", run_status, 2);
    check("R11 no request", reqs(), 0);
    write_ctl(1, 1, 0);
    check("R9 resume advances", reqs(), 2);
    check("R9 status running", run_status, 1);
    check("R9 cont self-clears", cont_bit, 0);
    step(); step();
    finish_desc(2'd1, 1'b0);
    write_ctl(1, 1, 1);
    check("R9 resume from start reloads", reqs(), 4);
    step(); step();
    finish_desc(2'd2, 1'b1);
    check("R6 stop status off", run_status, 0);
    check("R6 stop clears en_bit", en_bit, 0);
    check("R4 src_done on stop", src_done_evt, 1);
  endtask

  task automatic t_hold_exit();
    start_run("R10 setup");
    finish_desc(2'd1, 1'b0);
    write_ctl(0, 1, 0);
    check("R10 goes off", run_status, 0);
    check("R10 no request", reqs(), 0);
    step();
    check("R10 no request later", reqs(), 0);
  endtask

  task automatic t_fault();
    start_run("R3 setup");
    load_err = 1;
    step();
    load_err = 0;
    check("R3 fault code", run_status, 3);
    check("R3 no request", reqs(), 0);
    step();
    check("R3 fault persists", run_status, 3);
    write_ctl(1, 0, 0);
    check("R3 enable clears fault", run_status, 1);
    check("R3 restart reloads", reqs(), 4);
    step(); step();
    write_ctl(0, 0, 0);
    check("R11 write while running ignored", run_status, 1);
    check("R11 no request while running", reqs(), 0);
    list_mode = 0;
    finish_desc(2'd0, 1'b0);
    check("R5 register mode stops", run_status, 0);
    check("R5 no advance", reqs(), 0);
  endtask

  task automatic t_regmode_en();
    list_mode = 0;
    start_run("R5 setup");
    finish_desc(2'd1, 1'b0);
    check("R5 halt ignored in register mode", run_status, 0);
    check("R5 en_bit cleared", en_bit, 0);
    check("R5 no pause event", pause_evt, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_chain_advance();
    t_halt_resume();
    t_hold_exit();
    t_fault();
    t_regmode_en();
    step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule